// File: doc/BRIEF.md
# Latched Five-Digit Decade Tally

This block counts rising edges of a slow event input across four cascaded BCD decades plus a single overload digit, covering 00 000 to 19 999. A clear input empties the tally and a preset input fills it with 19 999. Both act at the next system clock edge and take priority over counting. A transfer input copies the tally into a bank of holding registers, so software or a display scanner can read a stable snapshot while counting goes on.

A three-bit select picks one held digit onto a 4-bit BCD bus. An enable input releases that bus to high impedance, so several tallies can share one bus. Four active-low carry flags show the all-nines state of the upper decades and the overload state. Downstream logic uses them to cascade or to raise alarms.

Top module: `decade_tally`

## Requirements
- R1: With clearIn HIGH, the next clock edge sets every decade and the overload digit to zero, whatever presetIn and countIn do.
- R2: With presetIn HIGH and clearIn LOW, the next clock edge loads 19 999 (all decades 9, overload 1), whatever countIn does.
- R3: A LOW-to-HIGH change of countIn, seen between two consecutive clock edges, adds one to the tally at the second edge, but only while clearIn and presetIn are both LOW.
- R4: While transferIn is HIGH, the holding registers take the tally value produced at the same clock edge. While it is LOW, they keep their contents.
- R5: A digitSel of 0, 1, 2 or 3 puts held decade 1 (least significant), 2, 3 or 4 on bcdOut.
- R6: Any digitSel with bit 2 set selects the overload digit: bcdOut[1] and bcdOut[0] both carry the held overload bit, and bcdOut[3:2] are LOW.
- R7: With outEnable LOW, bcdOut is high impedance.
- R8: carryN[0], carryN[1] and carryN[2] are LOW exactly when the lowest two, three or four decades, respectively, all hold 9.
- R9: While presetIn is HIGH and clearIn is LOW, carryN[2:0] are forced HIGH. When presetIn falls they go LOW, because 19 999 meets all three conditions.
- R10: carryN[3] is LOW exactly while the overload digit is 1. Preset does not mask it.
- R11: A counted edge at 19 999 wraps the tally to 00 000 and clears the overload digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset, empties tally and holding registers |
| countIn | input | 1 | Event input, counted on its rising change |
| clearIn | input | 1 | Clear request, highest priority |
| presetIn | input | 1 | Preset-to-19 999 request |
| transferIn | input | 1 | Copy tally into holding registers while HIGH |
| digitSel | input | 3 | Held digit select (bit 2 selects overload) |
| outEnable | input | 1 | Drive bcdOut when HIGH, release it when LOW |
| bcdOut | output | 4 | Selected held digit in BCD |
| carryN | output | 4 | Active-low carries: [0]=two decades, [1]=three, [2]=four all nines, [3]=overload |

## Verification
Clear, preset and counting each change the tally at the first clock edge after the input is applied. With transfer HIGH, the held value follows at that same edge. Every check is therefore made at the falling edge after that rising edge. The carry flags, digit select and output enable are combinational from registered state and the present inputs. They are sampled at that same falling edge, before the next stimulus is applied. A bench model advances once per rising edge with the same priorities, so each expected value is ready when the sample is taken.

// File: rtl/tally_pkg.sv
package tally_pkg;
  localparam int NUM_DECADES = 4;
  localparam int DIGIT_W     = 4;
  localparam int SEL_W       = $clog2(NUM_DECADES) + 1;

  typedef logic [DIGIT_W-1:0] bcdDigit_t;

  typedef struct packed {
    logic clear;
    logic preset;
    logic step;
    logic load;
  } tallyStrobes_t;
endpackage

// File: rtl/tally_ctrl.sv
module tally_ctrl
  import tally_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          countIn,
  input  logic          clearIn,
  input  logic          presetIn,
  input  logic          transferIn,
  output tallyStrobes_t strobes
);
  logic countPrevQ;
  logic countRise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) countPrevQ <= 1'b0;
    else        countPrevQ <= countIn;
  end

  assign countRise = countIn & ~countPrevQ;

  always_comb begin
    strobes.clear  = clearIn;
    strobes.preset = presetIn & ~clearIn;
    strobes.step   = countRise & ~clearIn & ~presetIn;
    strobes.load   = transferIn;
  end

  // R1 R2 R3: clear, preset and count never compete
  a_r3_exclusive_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.clear, strobes.preset, strobes.step}));

  // R3: a step needs countIn to have been LOW at the previous edge
  a_r3_step_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.step |-> (countIn && !countPrevQ));
endmodule

// File: rtl/tally_dp.sv
module tally_dp
  import tally_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  tallyStrobes_t      strobes,
  input  logic [SEL_W-1:0]   digitSel,
  output logic [DIGIT_W-1:0] busData,
  output logic [3:0]         carryN
);
  localparam bcdDigit_t MAX_DIGIT = bcdDigit_t'(9);

  bcdDigit_t digitQ   [NUM_DECADES];
  bcdDigit_t digitNxt [NUM_DECADES];
  bcdDigit_t heldQ    [NUM_DECADES];
  logic      ovfQ, ovfNxt, heldOvfQ;
  logic [NUM_DECADES:0] lowNine;

  assign lowNine[0] = 1'b1;

  for (genvar i = 0; i < NUM_DECADES; i++) begin : g_decade
    assign lowNine[i+1] = lowNine[i] & (digitQ[i] == MAX_DIGIT);

    always_comb begin
      if (strobes.clear)                    digitNxt[i] = '0;
      else if (strobes.preset)              digitNxt[i] = MAX_DIGIT;
      else if (strobes.step && lowNine[i])  digitNxt[i] = (digitQ[i] == MAX_DIGIT) ? '0 : digitQ[i] + 1'b1;
      else                                  digitNxt[i] = digitQ[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        digitQ[i] <= '0;
        heldQ[i]  <= '0;
      end else begin
        digitQ[i] <= digitNxt[i];
        if (strobes.load) heldQ[i] <= digitNxt[i];
      end
    end

    a_r3_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
      digitQ[i] <= MAX_DIGIT);
    a_r1_clear_digit: assert property (@(posedge clk) disable iff (!rst_n)
      strobes.clear |=> (digitQ[i] == '0));
    a_r2_preset_digit: assert property (@(posedge clk) disable iff (!rst_n)
      strobes.preset |=> (digitQ[i] == MAX_DIGIT));
    a_r4_hold_digit: assert property (@(posedge clk) disable iff (!rst_n)
      !strobes.load |=> $stable(heldQ[i]));
  end

  always_comb begin
    if (strobes.clear)                                 ovfNxt = 1'b0;
    else if (strobes.preset)                           ovfNxt = 1'b1;
    else if (strobes.step && lowNine[NUM_DECADES])     ovfNxt = ~ovfQ;
    else                                               ovfNxt = ovfQ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovfQ     <= 1'b0;
      heldOvfQ <= 1'b0;
    end else begin
      ovfQ <= ovfNxt;
      if (strobes.load) heldOvfQ <= ovfNxt;
    end
  end

  always_comb begin
    if (digitSel[SEL_W-1]) busData = {{(DIGIT_W-2){1'b0}}, heldOvfQ, heldOvfQ};
    else                   busData = heldQ[digitSel[SEL_W-2:0]];
  end

  for (genvar k = 2; k <= NUM_DECADES; k++) begin : g_carry
    assign carryN[k-2] = ~lowNine[k] | strobes.preset;
  end
  assign carryN[3] = ~ovfQ;

  // R11: a counted edge at full scale clears the overload digit
  a_r11_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.step && lowNine[NUM_DECADES] && ovfQ) |=> (!ovfQ && digitQ[0] == '0));
  // R1: clear empties the overload digit
  a_r1_clear_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clear |=> !ovfQ);
  // R2: preset sets the overload digit
  a_r2_preset_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.preset |=> ovfQ);
endmodule

// File: rtl/decade_tally.sv
module decade_tally
  import tally_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             countIn,
  input  logic             clearIn,
  input  logic             presetIn,
  input  logic             transferIn,
  input  logic [SEL_W-1:0] digitSel,
  input  logic             outEnable,
  output logic [3:0]       bcdOut,
  output logic [3:0]       carryN
);
  tallyStrobes_t strobes;
  logic [DIGIT_W-1:0] busData;

  tally_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .countIn(countIn), .clearIn(clearIn),
    .presetIn(presetIn), .transferIn(transferIn), .strobes(strobes)
  );

  tally_dp i_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .digitSel(digitSel),
    .busData(busData), .carryN(carryN)
  );

  assign bcdOut = outEnable ? busData : 4'bzzzz;

  // R9: carries below overload stay HIGH during an effective preset
  a_r9_preset_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (presetIn && !clearIn) |-> (carryN[2:0] == 3'b111));
endmodule

// File: tb/test_decade_tally.sv
module test_decade_tally;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic countIn = 0, clearIn = 0, presetIn = 0, transferIn = 0, outEnable = 0;
  logic [2:0] digitSel = '0;
  logic [3:0] bcdOut, carryN;

  int tests = 0, fails = 0, cycles = 0;
  int tally = 0, held = 0;
  logic cpPrev = 0;
  bit   finished = 0;

  decade_tally i_decade_tally (
    .clk(clk), .rst_n(rst_n), .countIn(countIn), .clearIn(clearIn),
    .presetIn(presetIn), .transferIn(transferIn), .digitSel(digitSel),
    .outEnable(outEnable), .bcdOut(bcdOut), .carryN(carryN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] expBus(int h, logic [2:0] s);
    if (s[2]) return {2'b00, logic'(h >= 10000), logic'(h >= 10000)};
    case (s[1:0])
      2'd0: return 4'(h % 10);
      2'd1: return 4'((h / 10) % 10);
      2'd2: return 4'((h / 100) % 10);
      default: return 4'((h / 1000) % 10);
    endcase
  endfunction

  function automatic logic [3:0] expCarry(int t, logic pre, logic clr);
    logic [3:0] c;
    logic mask;
    mask = pre & ~clr;
    c[0] = mask | !((t % 100) == 99);
    c[1] = mask | !((t % 1000) == 999);
    c[2] = mask | !((t % 10000) == 9999);
    c[3] = !(t >= 10000);
    return c;
  endfunction

  task automatic checkNow(string tag);
    logic [3:0] eb, ec;
    tests++;
    ec = expCarry(tally, presetIn, clearIn);
    if (carryN !== ec) begin
      fails++;
      $display("FAIL %s carry: actual %b expected %b (tally %0d)",
               presetIn ? "R9" : (carryN[3] !== ec[3] ? "R10" : "R8"), carryN, ec, tally);
    end
    tests++;
    if (!outEnable) begin
      if (!(bcdOut === 4'bzzzz || bcdOut === 4'b0000)) begin
        fails++;
        $display("FAIL R7 bus: actual %b expected zzzz", bcdOut);
      end
    end else begin
      eb = expBus(held, digitSel);
      if (bcdOut !== eb) begin
        fails++;
        $display("FAIL %s bus sel %0d: actual %b expected %b (held %0d)",
                 tag.len() ? tag : (digitSel[2] ? "R6" : "R5"), digitSel, bcdOut, eb, held);
      end
    end
  endtask

  task automatic step(logic cp, logic clr, logic pre, logic t, logic [2:0] s, logic oe, string tag);
    countIn = cp; clearIn = clr; presetIn = pre; transferIn = t; digitSel = s; outEnable = oe;
    @(posedge clk);
    cycles++;
    if (clr) tally = 0;
    else if (pre) tally = 19999;
    else if (cp && !cpPrev) tally = (tally == 19999) ? 0 : tally + 1;
    cpPrev = cp;
    if (t) held = tally;
    @(negedge clk);
    checkNow(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    outEnable = 1;
    checkNow("R1");                                   // reset state
    rst_n = 1;
    @(negedge clk);

    // R1: clear beats preset and count
    step(1, 1, 1, 1, 3'd0, 1, "R1");
    step(0, 0, 0, 1, 3'd4, 1, "R1");
    // R2: preset loads 19 999, carries masked (R9)
    step(1, 0, 1, 1, 3'd3, 1, "R2");
    step(0, 0, 1, 1, 3'd4, 1, "R2");
    // R9: release preset, carries fall
    step(0, 0, 0, 1, 3'd0, 1, "R9");
    // R11: wrap at full scale
    step(1, 0, 0, 1, 3'd4, 1, "R11");
    step(1, 0, 0, 1, 3'd0, 1, "R3");                  // level HIGH: no count
    // R4: hold while transfer LOW
    step(0, 0, 0, 0, 3'd0, 1, "R4");
    step(1, 0, 0, 0, 3'd0, 1, "R4");
    step(0, 0, 0, 1, 3'd0, 1, "R4");
    // R7: released bus
    step(0, 0, 0, 1, 3'd1, 0, "R7");
    // R8 R10 R11: long count across every decade boundary and past 10 000
    for (int n = 0; n < 20010; n++) begin
      step(1, 0, 0, 1, 3'(n % 5), 1, "");
      step(0, 0, 0, (n % 7) != 0, 3'((n + 2) % 8), 1, "");
    end
    // constrained random mix
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < 30000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], (r[15:10] == 0), (r[21:16] == 1), r[2], r[5:3], (r[7:6] != 0), "");
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (MAX_CYCLES * 2) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule